// File: doc/BRIEF.md
# Line-Burst LCD Refresh Engine

This block keeps a parallel RGB TFT panel refreshed from a frame buffer without a dedicated display controller. It walks the frame row by row, fetches the visible pixels of each row from a synchronous memory read port, and presents every pixel on a 24-bit colour bus together with a pixel strobe. That strobe is the panel's pixel clock. The pixels of a row are fetched in bursts of `BURST_LEN`. The first burst of a row starts on its own. Every later burst waits for a single-cycle trigger pulse from an external interval timer, so the fetch rate can be kept below what a shared memory can sustain.

Every row is made of strobed pixel slots: first the visible segment, then a horizontal front porch, a sync segment and a back porch. The frame is made of sync rows, back-porch rows, visible rows and front-porch rows, in that order. All eight lengths are inputs and are captured once per frame. With a strobe frequency `F`, the refresh rate is `F / (row slots * frame rows)`. The width parameters are large enough to reach about 60 Hz on common panel sizes. The frame buffer holds pixels in either a 3-3-2 byte format or a 5-6-5 word format, and both are widened to 8 bits per channel. A pause input stops the engine at a safe point and holds its state. A line-end pulse marks each row boundary so that an external counter can be cleared there.

Top module: `lcd_line_streamer`

## Requirements
- R1: Each frame is sent as `vSyncW` sync rows, `vBack` back-porch rows, `vActive` visible rows and `vFront` front-porch rows, in that order, and then repeats. Each row is `hActive` pixel slots, then `hFront`, `hSyncW` and `hBack` slots. `vSync` is high on every slot of the sync rows. `hSync` is high on the `hSyncW` sync slots of every row. Both are active high and both are low whenever `den` is high.
- R2: In a visible row, the first burst of up to `BURST_LEN` pixels starts without a trigger. Each later burst starts only after a `burstKick` pulse that arrives while the engine is waiting. A pulse that arrives while the engine is not waiting is dropped.
- R3: Each pixel slot gives exactly one `pixStrobe` pulse, one clock cycle long, and no two pulses fall in adjacent cycles. `pixData`, `hSync`, `vSync` and `den` take their new values one cycle before the pulse and hold them through it.
- R4: `den` is high exactly on the visible slots of the visible rows. On every other slot `pixData` is zero.
- R5: All eight timing inputs and `wideMode` are captured at the start of each frame and stay in force for that whole frame. Each timing value must be at least 1.
- R6: With `wideMode` = 0, the low byte of a memory word holds red in bits [7:5], green in [4:2] and blue in [1:0]. Each channel is widened to 8 bits by repeating its bits from the most significant bit down. `pixData` carries red in [23:16], green in [15:8] and blue in [7:0], so 8'hFF gives full white and 8'h00 gives black.
- R7: With `wideMode` = 1, the memory word holds red in [15:11], green in [10:5] and blue in [4:0]. Each channel is widened the same way, so 16'hFFFF gives 24'hFFFFFF and 16'h0000 gives zero.
- R8: `lineDone` pulses together with the strobe of the last visible-segment slot (slot `hActive`-1) of every row, and it never pulses without a strobe.
- R9: While `pause` is high, any burst already in progress completes. After that no read and no strobe occur, and all outputs hold their values. When `pause` falls, the sequence continues exactly where it stopped.
- R10: Visible pixel (row r, column c) is read from address `r*hActive + c`, counted from 0 at each frame start. The read is issued three cycles before the strobe of that pixel.
- R11: While `rstN` is low, `pixData`, `pixStrobe`, `hSync`, `vSync`, `den`, `lineDone` and `memRdEn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pause | input | 1 | Hold the engine at the next safe point |
| burstKick | input | 1 | Single-cycle trigger for the next burst of a row |
| wideMode | input | 1 | 0: 3-3-2 byte pixels, 1: 5-6-5 word pixels |
| hActive | input | H_W | Visible slots per row |
| hFront | input | H_W | Horizontal front porch slots |
| hSyncW | input | H_W | Horizontal sync slots |
| hBack | input | H_W | Horizontal back porch slots |
| vActive | input | V_W | Visible rows per frame |
| vFront | input | V_W | Vertical front porch rows |
| vSyncW | input | V_W | Vertical sync rows |
| vBack | input | V_W | Vertical back porch rows |
| memRdData | input | 16 | Read data, valid one cycle after `memRdEn` |
| memRdEn | output | 1 | Read request |
| memAddr | output | ADDR_W | Read address |
| pixData | output | 24 | Widened RGB pixel |
| pixStrobe | output | 1 | Pixel clock pulse |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| den | output | 1 | Data enable |
| lineDone | output | 1 | Row boundary pulse |

## Verification
The assertions assume the following about the inputs. Every timing input is at least 1. The memory answers exactly one cycle after a read request. `burstKick` is a single-cycle pulse. Timing inputs change only well inside a frame, never in the cycle where the engine captures them. The stimulus keeps within these limits: it holds the timing inputs at nonzero values, models the memory with a fixed one-cycle latency, and drives kicks from a cycle divider or as single-cycle pulses. It reprograms the timing only after many strobes of the current frame have gone out, and it toggles `pause` and the kick only on falling clock edges.

// File: rtl/lcd_stream_pkg.sv
package lcd_stream_pkg;

  localparam int MEM_W = 16;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef enum logic [1:0] {V_SYNC, V_BACK, V_ACT, V_FRONT} vRegion_e;
  typedef enum logic [1:0] {H_ACT, H_FRONT, H_SYNC, H_BACK} hSeg_e;

  // per-slot strobes from control to datapath
  typedef struct packed {
    logic load;      // slot second phase: capture pixel and sync levels
    logic pixValid;  // visible pixel, memory data valid
    logic hs;
    logic vs;
    logic lastCol;   // last slot of the visible segment
    logic wide;      // 5-6-5 format in force for this frame
  } pixCtl_t;

endpackage

// File: rtl/lcd_stream_ctrl.sv
module lcd_stream_ctrl
  import lcd_stream_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 10,
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pause,
  input  logic              burstKick,
  input  logic              wideMode,
  input  logic [H_W-1:0]    hActive,
  input  logic [H_W-1:0]    hFront,
  input  logic [H_W-1:0]    hSyncW,
  input  logic [H_W-1:0]    hBack,
  input  logic [V_W-1:0]    vActive,
  input  logic [V_W-1:0]    vFront,
  input  logic [V_W-1:0]    vSyncW,
  input  logic [V_W-1:0]    vBack,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output pixCtl_t           ctl
);

  localparam int BC_W = $clog2(BURST_LEN + 1);
  localparam logic [BC_W-1:0] BURST_LAST = BC_W'(BURST_LEN - 1);
  localparam logic [H_W-1:0]  H_ONE = 1;
  localparam logic [V_W-1:0]  V_ONE = 1;

  // frame-captured timing
  logic [H_W-1:0] cHA, cHF, cHS, cHB;
  logic [V_W-1:0] cVA, cVF, cVS, cVB;
  logic           cWide;

  logic              needLoad, ph, waitKick;
  vRegion_e          vReg;
  hSeg_e             hSeg;
  logic [H_W-1:0]    hCnt, hLen;
  logic [V_W-1:0]    vCnt, vLen;
  logic [BC_W-1:0]   burstCnt;
  logic [ADDR_W-1:0] rdAddr;
  logic              actPix, atBurstStart, startSlot, segEnd;

  always_comb begin
    case (hSeg)
      H_ACT:   hLen = cHA;
      H_FRONT: hLen = cHF;
      H_SYNC:  hLen = cHS;
      default: hLen = cHB;
    endcase
    case (vReg)
      V_SYNC:  vLen = cVS;
      V_BACK:  vLen = cVB;
      V_ACT:   vLen = cVA;
      default: vLen = cVF;
    endcase
  end

  assign actPix       = (vReg == V_ACT) && (hSeg == H_ACT);
  assign atBurstStart = !actPix || (burstCnt == '0);
  assign startSlot    = !needLoad && !ph && !waitKick && !(pause && atBurstStart);
  assign segEnd       = (hCnt == hLen - H_ONE);

  assign memRdEn = startSlot && actPix;
  assign memAddr = rdAddr;

  assign ctl.load     = ph;
  assign ctl.pixValid = actPix;
  assign ctl.hs       = (hSeg == H_SYNC);
  assign ctl.vs       = (vReg == V_SYNC);
  assign ctl.lastCol  = (hSeg == H_ACT) && (hCnt == cHA - H_ONE);
  assign ctl.wide     = cWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {cHA, cHF, cHS, cHB} <= '0;
      {cVA, cVF, cVS, cVB} <= '0;
      cWide    <= 1'b0;
      needLoad <= 1'b1;
      ph       <= 1'b0;
      waitKick <= 1'b0;
      vReg     <= V_SYNC;
      hSeg     <= H_ACT;
      hCnt     <= '0;
      vCnt     <= '0;
      burstCnt <= '0;
      rdAddr   <= '0;
    end else begin
      if (waitKick && burstKick) waitKick <= 1'b0;
      if (needLoad) begin
        cHA <= hActive; cHF <= hFront; cHS <= hSyncW; cHB <= hBack;
        cVA <= vActive; cVF <= vFront; cVS <= vSyncW; cVB <= vBack;
        cWide    <= wideMode;
        needLoad <= 1'b0;
      end else if (startSlot) begin
        ph <= 1'b1;
      end else if (ph) begin
        ph   <= 1'b0;
        hCnt <= hCnt + H_ONE;
        if (actPix) begin
          rdAddr   <= rdAddr + 1'b1;
          burstCnt <= burstCnt + 1'b1;
        end
        if (segEnd) begin
          hCnt     <= '0;
          burstCnt <= '0;
          case (hSeg)
            H_ACT:   hSeg <= H_FRONT;
            H_FRONT: hSeg <= H_SYNC;
            H_SYNC:  hSeg <= H_BACK;
            default: begin
              hSeg <= H_ACT;
              vCnt <= vCnt + V_ONE;
              if (vCnt == vLen - V_ONE) begin
                vCnt <= '0;
                case (vReg)
                  V_SYNC:  vReg <= V_BACK;
                  V_BACK:  vReg <= V_ACT;
                  V_ACT:   vReg <= V_FRONT;
                  default: begin
                    vReg     <= V_SYNC;
                    needLoad <= 1'b1;
                    rdAddr   <= '0;
                  end
                endcase
              end
            end
          endcase
        end else if (actPix && burstCnt == BURST_LAST) begin
          burstCnt <= '0;
          waitKick <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_stream_dpath.sv
module lcd_stream_dpath
  import lcd_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pixCtl_t          ctl,
  input  logic [MEM_W-1:0] memRdData,
  output logic [RGB_W-1:0] pixData,
  output logic             pixStrobe,
  output logic             hSync,
  output logic             vSync,
  output logic             den,
  output logic             lineDone
);

  logic             loadQ, lastQ;
  logic [RGB_W-1:0] rgbWide, rgbNarrow, rgbSel;

  // channel widening: replicate from the MSB downward
  assign rgbNarrow = {memRdData[7:5], memRdData[7:5], memRdData[7:6],
                      memRdData[4:2], memRdData[4:2], memRdData[4:3],
                      {4{memRdData[1:0]}}};
  assign rgbWide   = {memRdData[15:11], memRdData[15:13],
                      memRdData[10:5],  memRdData[10:9],
                      memRdData[4:0],   memRdData[4:2]};
  assign rgbSel    = ctl.wide ? rgbWide : rgbNarrow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ     <= 1'b0;
      lastQ     <= 1'b0;
      pixStrobe <= 1'b0;
      lineDone  <= 1'b0;
      pixData   <= '0;
      hSync     <= 1'b0;
      vSync     <= 1'b0;
      den       <= 1'b0;
    end else begin
      loadQ     <= ctl.load;
      lastQ     <= ctl.load && ctl.lastCol;
      pixStrobe <= loadQ;
      lineDone  <= lastQ;
      if (ctl.load) begin
        pixData <= ctl.pixValid ? rgbSel : '0;
        hSync   <= ctl.hs;
        vSync   <= ctl.vs;
        den     <= ctl.pixValid;
      end
    end
  end

endmodule

// File: rtl/lcd_line_streamer.sv
module lcd_line_streamer
  import lcd_stream_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 10,
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pause,
  input  logic              burstKick,
  input  logic              wideMode,
  input  logic [H_W-1:0]    hActive,
  input  logic [H_W-1:0]    hFront,
  input  logic [H_W-1:0]    hSyncW,
  input  logic [H_W-1:0]    hBack,
  input  logic [V_W-1:0]    vActive,
  input  logic [V_W-1:0]    vFront,
  input  logic [V_W-1:0]    vSyncW,
  input  logic [V_W-1:0]    vBack,
  input  logic [15:0]       memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [23:0]       pixData,
  output logic              pixStrobe,
  output logic              hSync,
  output logic              vSync,
  output logic              den,
  output logic              lineDone
);

  pixCtl_t ctl;

  lcd_stream_ctrl #(
    .H_W(H_W), .V_W(V_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pause(pause), .burstKick(burstKick),
    .wideMode(wideMode),
    .hActive(hActive), .hFront(hFront), .hSyncW(hSyncW), .hBack(hBack),
    .vActive(vActive), .vFront(vFront), .vSyncW(vSyncW), .vBack(vBack),
    .memRdEn(memRdEn), .memAddr(memAddr), .ctl(ctl)
  );

  lcd_stream_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .pixData(pixData), .pixStrobe(pixStrobe), .hSync(hSync),
    .vSync(vSync), .den(den), .lineDone(lineDone)
  );

endmodule

// File: rtl/lcd_stream_chk.sv
module lcd_stream_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memRdEn,
  input logic [23:0] pixData,
  input logic        pixStrobe,
  input logic        hSync,
  input logic        vSync,
  input logic        den,
  input logic        lineDone
);

  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |=> !pixStrobe);

  p_held_under_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |-> ($stable(pixData) && $stable(den) && $stable(hSync) && $stable(vSync)));

  p_levels_lead_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(hSync) || !$stable(vSync) || !$stable(den)) |=> pixStrobe);

  p_den_excludes_sync_r1: assert property (@(posedge clk) disable iff (!rstN)
    den |-> (!hSync && !vSync));

  p_blank_is_black_r4: assert property (@(posedge clk) disable iff (!rstN)
    !den |-> (pixData == 24'h0));

  p_read_to_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ##3 (pixStrobe && den));

  p_line_on_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> pixStrobe);

endmodule

bind lcd_line_streamer lcd_stream_chk u_chk (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .pixData(pixData),
  .pixStrobe(pixStrobe), .hSync(hSync), .vSync(vSync), .den(den),
  .lineDone(lineDone)
);

// File: tb/sim_lcd_line_streamer.sv
`timescale 1ns/1ps
module sim_lcd_line_streamer;

  localparam int H_W = 11, V_W = 10, ADDR_W = 19, BL = 4;

  typedef struct {
    int hA, hF, hS, hB, vA, vF, vS, vB;
    bit wide;
  } cfg_t;

  logic clk = 0, rstN = 0, pause = 0, burstKick = 0, wideMode = 0;
  logic [H_W-1:0] hActive = 1, hFront = 1, hSyncW = 1, hBack = 1;
  logic [V_W-1:0] vActive = 1, vFront = 1, vSyncW = 1, vBack = 1;
  logic [15:0] memRdData = 0;
  logic memRdEn, pixStrobe, hSync, vSync, den, lineDone;
  logic [ADDR_W-1:0] memAddr;
  logic [23:0] pixData;

  int checks = 0, errors = 0;
  int idx = 0, frames = 0, strobeCnt = 0, denCnt = 0, lineCnt = 0, expRd = 0;
  bit kickEn = 0, kickManual = 0, prevStrobe = 0, rdReq = 0;
  int kickDiv = 0;
  logic [23:0] prevData = 0;
  int rdAddrS = 0;
  cfg_t cfgCur, cfgNext, cfgA, cfgB;

  always #2 clk = ~clk;

  lcd_line_streamer #(.H_W(H_W), .V_W(V_W), .ADDR_W(ADDR_W), .BURST_LEN(BL)) u0 (
    .clk(clk), .rstN(rstN), .pause(pause), .burstKick(burstKick),
    .wideMode(wideMode), .hActive(hActive), .hFront(hFront), .hSyncW(hSyncW),
    .hBack(hBack), .vActive(vActive), .vFront(vFront), .vSyncW(vSyncW),
    .vBack(vBack), .memRdData(memRdData), .memRdEn(memRdEn), .memAddr(memAddr),
    .pixData(pixData), .pixStrobe(pixStrobe), .hSync(hSync), .vSync(vSync),
    .den(den), .lineDone(lineDone)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memFn(int a);
    if (a == 0) return 16'hFFFF;
    if (a == 1) return 16'h0000;
    return 16'(a * 40503 + 4660);
  endfunction

  function automatic logic [7:0] stretch(logic [7:0] v, int bits);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[7-i] = v[bits - 1 - (i % bits)];
    return o;
  endfunction

  function automatic logic [23:0] expect24(logic [15:0] w, bit wide);
    if (wide) return {stretch(8'(w[15:11]), 5), stretch(8'(w[10:5]), 6), stretch(8'(w[4:0]), 5)};
    return {stretch(8'(w[7:5]), 3), stretch(8'(w[4:2]), 3), stretch(8'(w[1:0]), 2)};
  endfunction

  // memory model: request sampled mid-cycle, data returned at the next edge
  always @(negedge clk) begin
    rdReq = 0;
    if (!rstN) expRd = 0;
    else if (memRdEn) begin
      rdReq = 1;
      rdAddrS = int'(memAddr);
      check(rdAddrS == expRd, "R10", "read address", rdAddrS, expRd);
      expRd = (expRd + 1) % (cfgCur.vA * cfgCur.hA);
    end
  end
  always @(posedge clk) if (rdReq) memRdData <= memFn(rdAddrS);

  // trigger source
  always @(negedge clk) begin
    kickDiv = (kickDiv + 1) % 8;
    burstKick = (kickEn && kickDiv == 0) || kickManual;
  end

  // strobe-by-strobe reference model
  always @(negedge clk) begin
    if (!rstN) begin
      idx = 0; cfgCur = cfgNext; prevStrobe = 0; prevData = 0;
    end else begin
      if (lineDone && !pixStrobe) check(0, "R8", "lineDone without strobe", 1, 0);
      if (pixStrobe) begin
        int hT, vT, row, col, addr;
        bit eVs, eHs, eDen, actRow;
        logic [23:0] eData;
        hT = cfgCur.hA + cfgCur.hF + cfgCur.hS + cfgCur.hB;
        vT = cfgCur.vS + cfgCur.vB + cfgCur.vA + cfgCur.vF;
        row = idx / hT; col = idx % hT;
        eVs = row < cfgCur.vS;
        actRow = row >= cfgCur.vS + cfgCur.vB && row < cfgCur.vS + cfgCur.vB + cfgCur.vA;
        eHs = col >= cfgCur.hA + cfgCur.hF && col < cfgCur.hA + cfgCur.hF + cfgCur.hS;
        eDen = actRow && col < cfgCur.hA;
        addr = (row - cfgCur.vS - cfgCur.vB) * cfgCur.hA + col;
        eData = eDen ? expect24(memFn(addr), cfgCur.wide) : 24'h0;
        check(!prevStrobe, "R3", "strobe gap", 1, 0);
        check(pixData == prevData, "R3", "data held before strobe", pixData, prevData);
        check(vSync == eVs && hSync == eHs, "R1", "sync levels {v,h}",
              {vSync, hSync}, {eVs, eHs});
        check(den == eDen, "R4", "den", den, eDen);
        check(pixData == eData, cfgCur.wide ? "R7" : "R6", "pixel data", pixData, eData);
        check(lineDone == (col == cfgCur.hA - 1), "R8", "lineDone", lineDone,
              col == cfgCur.hA - 1);
        strobeCnt++;
        if (den) denCnt++;
        if (lineDone) lineCnt++;
        idx++;
        if (idx == hT * vT) begin idx = 0; cfgCur = cfgNext; frames++; end
      end
      prevStrobe = pixStrobe;
      prevData = pixData;
    end
  end

  task automatic applyCfg(cfg_t c);
    hActive = H_W'(c.hA); hFront = H_W'(c.hF); hSyncW = H_W'(c.hS); hBack = H_W'(c.hB);
    vActive = V_W'(c.vA); vFront = V_W'(c.vF); vSyncW = V_W'(c.vS); vBack = V_W'(c.vB);
    wideMode = c.wide;
    cfgNext = c;
  endtask

  task automatic doReset(cfg_t c);
    @(negedge clk);
    rstN = 0; pause = 0;
    applyCfg(c);
    frames = 0; strobeCnt = 0; denCnt = 0; lineCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic pulseKick();
    @(posedge clk); #1 kickManual = 1;
    @(posedge clk); #1 kickManual = 0;
  endtask

  task automatic waitFrames(int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic waitFirstTwoPixels(string req);
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!(pixStrobe && den));
      check(pixData == (k == 0 ? 24'hFFFFFF : 24'h0), req, "white/black pixel",
            pixData, k == 0 ? 24'hFFFFFF : 24'h0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rstN = 0; applyCfg(cfgA);
    repeat (2) @(negedge clk);
    check(pixData == 0 && !pixStrobe && !hSync && !vSync && !den && !lineDone && !memRdEn,
          "R11", "outputs in reset",
          {pixData, pixStrobe, hSync, vSync, den, lineDone, memRdEn}, 0);
  endtask

  task automatic t_frame8();
    kickEn = 1;
    doReset(cfgA);
    waitFirstTwoPixels("R6");
    waitFrames(2);
    check(denCnt == 24, "R4", "visible strobes in two frames", denCnt, 24);
    check(lineCnt == 10, "R8", "row pulses in two frames", lineCnt, 10);
  endtask

  task automatic t_frame16();
    kickEn = 1;
    doReset(cfgB);
    waitFirstTwoPixels("R7");
    waitFrames(2);
    check(denCnt == 20, "R7", "visible strobes in two frames", denCnt, 20);
  endtask

  task automatic t_kick();
    kickEn = 0;
    doReset(cfgA);
    repeat (10) @(negedge clk);
    pulseKick();  // engine is not waiting: must be dropped
    for (int g = 0; g < 500 && denCnt < BL; g++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(denCnt == BL, "R2", "first burst then wait", denCnt, BL);
    pulseKick();
    repeat (60) @(negedge clk);
    check(denCnt == 10, "R2", "second burst plus next row first burst", denCnt, 10);
    kickEn = 1;
    waitFrames(1);
  endtask

  task automatic t_pause();
    int s0; logic [23:0] d0; logic [2:0] l0;
    kickEn = 1;
    doReset(cfgA);
    while (denCnt < 1) @(negedge clk);
    pause = 1;
    repeat (30) @(negedge clk);
    check(denCnt == BL, "R9", "burst in flight completes", denCnt, BL);
    s0 = strobeCnt; d0 = pixData; l0 = {hSync, vSync, den};
    repeat (60) @(negedge clk);
    check(strobeCnt == s0, "R9", "no strobe while paused", strobeCnt, s0);
    check(pixData == d0 && {hSync, vSync, den} == l0, "R9", "outputs held",
          {pixData, hSync, vSync, den}, {d0, l0});
    pause = 0;
    waitFrames(1);
    check(denCnt == 12, "R9", "frame completes after resume", denCnt, 12);
  endtask

  task automatic t_cfgChange();
    kickEn = 1;
    doReset(cfgA);
    while (strobeCnt < 15) @(negedge clk);
    applyCfg(cfgB);
    waitFrames(2);
    check(denCnt == 22, "R5", "old timing kept for current frame", denCnt, 22);
    check(strobeCnt == 50 + 45, "R5", "strobes per frame old then new", strobeCnt, 95);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfgA = '{hA: 6, hF: 1, hS: 2, hB: 1, vA: 2, vF: 1, vS: 1, vB: 1, wide: 0};
    cfgB = '{hA: 5, hF: 1, hS: 2, hB: 1, vA: 2, vF: 1, vS: 1, vB: 1, wide: 1};
    cfgNext = cfgA; cfgCur = cfgA;
    t_reset();
    t_frame8();
    t_frame16();
    t_kick();
    t_pause();
    t_cfgChange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule